// File: doc/BRIEF.md
# JPEG Quantization Table Generator

This block turns a single image quality setting into the two quantization tables a baseline JPEG encoder needs: one for luminance and one for chrominance. A host pulses a start strobe with a quality value. The block then maps the quality to a nonlinear scale factor. It walks both fixed base tables, scales each coefficient with rounding and range limits, and stores the 128 results in a small internal table memory.

The encoder datapath reads the finished tables through a synchronous read port at any time between runs. A done flag tells the host that every entry has been written. An optional baseline limit caps entries at 8 bits. The entry datapath accepts one coefficient per cycle. It uses one multiply and a divide by 100 built from a reciprocal multiply. The scale factor for low qualities comes from a short sequential divider.

Top module: `qtg_top`

## Requirements
- R1: The quality input is limited to 1..100 when it is captured. A value of 0 behaves as 1, and a value above 100 behaves as 100.
- R2: The scale factor is floor(5000 / q) when the limited quality q is below 50, and 200 - 2q otherwise.
- R3: Each entry equals floor((base * scale + 50) / 100), which is the scaled base value rounded to the nearest integer.
- R4: An entry that would be below 1 is stored as 1. An entry above 32767 is stored as 32767.
- R5: When the baseline input is high at the accepted start, every entry above 255 is stored as 255. When it is low, no 8-bit limit applies.
- R6: Table 0 is built from the standard luminance base table and table 1 from the standard chrominance base table, both in natural row-major order. rd_tbl selects the table and rd_idx the entry. rd_data shows the entry one clock after the address is sampled.
- R7: busy is high from the cycle after an accepted start until the run ends. done rises when all 128 entries have been written. done stays high until the next accepted start.
- R8: A start pulse while busy is ignored. The run in progress finishes with the quality and baseline setting it captured.
- R9: Outside a run, reading the same address always returns the same value.
- R10: After reset, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when not busy |
| quality | input | 7 | Quality setting, captured at the accepted start |
| baseline | input | 1 | Enables the 8-bit entry limit, captured at the accepted start |
| busy | output | 1 | Generation in progress |
| done | output | 1 | All entries written since the last accepted start |
| rd_tbl | input | 1 | Table select for reads (0 luma, 1 chroma) |
| rd_idx | input | 6 | Entry index for reads |
| rd_data | output | 16 | Read data, one cycle after the address |

## Verification
The hardest condition to reach from the ports is a second start request arriving while a run is partway through the entry pipeline. This request must leave no trace in the stored tables. The bench starts a run at low quality with the baseline limit off. A few cycles later it pulses start again with a high quality and the limit on. It then reads back all 128 entries and compares them with the first setting. The extremes of the clamps are reached by sweeping every quality from 0 to 110 with the baseline limit alternating. This includes quality 100, where the scale factor is zero and every entry must come out as 1.

// File: rtl/qtg_pkg.sv
package qtg_pkg;

    localparam int NUM_TBL    = 2;
    localparam int TBL_DEPTH  = 64;
    localparam int IDX_W      = $clog2(TBL_DEPTH);
    localparam int ADDR_W     = IDX_W + $clog2(NUM_TBL);
    localparam int ENTRY_W    = 16;
    localparam int BASE_W     = 8;
    localparam int QUAL_W     = 7;
    localparam int QUAL_MAX   = 100;
    localparam int QUAL_KNEE  = 50;
    localparam int SCALE_NUM  = 5000;
    localparam int SCALE_W    = $clog2(SCALE_NUM + 1);
    localparam int PROD_W     = BASE_W + SCALE_W;
    localparam int ENTRY_MAX  = 32767;
    localparam int BASE_LIMIT = 255;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCALE,
        ST_FILL,
        ST_DRAIN
    } gen_state_e;

    typedef struct packed {
        logic              tbl;
        logic [IDX_W-1:0]  idx;
    } entry_addr_t;

    typedef struct packed {
        logic              valid;
        entry_addr_t       addr;
        logic [PROD_W-1:0] prod;
    } prod_stage_t;

    localparam logic [BASE_W-1:0] LUMA_BASE [TBL_DEPTH] = '{
        8'd16, 8'd11, 8'd10, 8'd16, 8'd24, 8'd40, 8'd51, 8'd61,
        8'd12, 8'd12, 8'd14, 8'd19, 8'd26, 8'd58, 8'd60, 8'd55,
        8'd14, 8'd13, 8'd16, 8'd24, 8'd40, 8'd57, 8'd69, 8'd56,
        8'd14, 8'd17, 8'd22, 8'd29, 8'd51, 8'd87, 8'd80, 8'd62,
        8'd18, 8'd22, 8'd37, 8'd56, 8'd68, 8'd109, 8'd103, 8'd77,
        8'd24, 8'd35, 8'd55, 8'd64, 8'd81, 8'd104, 8'd113, 8'd92,
        8'd49, 8'd64, 8'd78, 8'd87, 8'd103, 8'd121, 8'd120, 8'd101,
        8'd72, 8'd92, 8'd95, 8'd98, 8'd112, 8'd100, 8'd103, 8'd99
    };

    localparam logic [BASE_W-1:0] CHROMA_BASE [TBL_DEPTH] = '{
        8'd17, 8'd18, 8'd24, 8'd47, 8'd99, 8'd99, 8'd99, 8'd99,
        8'd18, 8'd21, 8'd26, 8'd66, 8'd99, 8'd99, 8'd99, 8'd99,
        8'd24, 8'd26, 8'd56, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99,
        8'd47, 8'd66, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99,
        8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99,
        8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99,
        8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99,
        8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99, 8'd99
    };

    function automatic logic [BASE_W-1:0] base_coef(input entry_addr_t a);
        return a.tbl ? CHROMA_BASE[a.idx] : LUMA_BASE[a.idx];
    endfunction

    function automatic logic [QUAL_W-1:0] limit_quality(input logic [QUAL_W-1:0] q);
        if (q == '0)
            return QUAL_W'(1);
        else if (int'(q) > QUAL_MAX)
            return QUAL_W'(QUAL_MAX);
        else
            return q;
    endfunction

endpackage

// File: rtl/qtg_scale.sv
module qtg_scale
    import qtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [QUAL_W-1:0]  q,
    output logic               ready,
    output logic [SCALE_W-1:0] scale
);
    localparam int CNT_W = $clog2(SCALE_W + 1);
    localparam logic [SCALE_W-1:0] NUMER = SCALE_W'(SCALE_NUM);

    logic               running;
    logic [CNT_W-1:0]   bit_cnt;
    logic [QUAL_W:0]    rem;
    logic [SCALE_W-1:0] quo;
    logic [QUAL_W-1:0]  divisor;
    logic [QUAL_W:0]    rem_shift;
    logic               fits;

    always_comb begin
        rem_shift = {rem[QUAL_W-1:0], NUMER[bit_cnt - CNT_W'(1)]};
        fits      = rem_shift >= {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            bit_cnt <= '0;
            rem     <= '0;
            quo     <= '0;
            divisor <= '0;
            ready   <= 1'b0;
            scale   <= '0;
        end else begin
            ready <= 1'b0;
            if (go) begin
                if (int'(q) >= QUAL_KNEE) begin
                    scale <= SCALE_W'(200) - SCALE_W'({q, 1'b0});
                    ready <= 1'b1;
                end else begin
                    running <= 1'b1;
                    bit_cnt <= CNT_W'(SCALE_W);
                    rem     <= '0;
                    quo     <= '0;
                    divisor <= q;
                end
            end else if (running) begin
                rem     <= fits ? rem_shift - {1'b0, divisor} : rem_shift;
                quo     <= {quo[SCALE_W-2:0], fits};
                bit_cnt <= bit_cnt - CNT_W'(1);
                if (bit_cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    ready   <= 1'b1;
                    scale   <= {quo[SCALE_W-2:0], fits};
                end
            end
        end
    end

endmodule

// File: rtl/qtg_entry_pipe.sv
module qtg_entry_pipe
    import qtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  entry_addr_t        in_addr,
    input  logic [SCALE_W-1:0] scale,
    input  logic               baseline,
    output logic               out_valid,
    output entry_addr_t        out_addr,
    output logic [ENTRY_W-1:0] out_val
);
    localparam int RSHIFT = PROD_W + 7;
    localparam longint RECIP = ((64'd1 << RSHIFT) + 64'd99) / 64'd100;
    localparam int RECIP_W = RSHIFT - 6;
    localparam int QUO_W = PROD_W - 6;

    prod_stage_t              s1;
    logic [PROD_W+RECIP_W-1:0] wide;
    logic [QUO_W-1:0]         quo;
    logic [ENTRY_W-1:0]       limited;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            s1.addr  <= in_addr;
            s1.prod  <= PROD_W'(base_coef(in_addr)) * PROD_W'(scale) + PROD_W'(50);
        end
    end

    always_comb begin
        wide = (PROD_W+RECIP_W)'(s1.prod) * (PROD_W+RECIP_W)'(RECIP);
        quo  = QUO_W'(wide >> RSHIFT);
        if (quo == '0)
            limited = ENTRY_W'(1);
        else if (int'(quo) > ENTRY_MAX)
            limited = ENTRY_W'(ENTRY_MAX);
        else
            limited = ENTRY_W'(quo);
        if (baseline && int'(limited) > BASE_LIMIT)
            limited = ENTRY_W'(BASE_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_val   <= '0;
        end else begin
            out_valid <= s1.valid;
            out_addr  <= s1.addr;
            out_val   <= limited;
        end
    end

endmodule

// File: rtl/qtg_table_ram.sv
module qtg_table_ram
    import qtg_pkg::*;
(
    input  logic               clk,
    input  logic               wr_en,
    input  entry_addr_t        wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  entry_addr_t        rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);
    localparam int WORDS = NUM_TBL * TBL_DEPTH;

    logic [ENTRY_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/qtg_top.sv
module qtg_top
    import qtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [QUAL_W-1:0]  quality,
    input  logic               baseline,
    output logic               busy,
    output logic               done,
    input  logic               rd_tbl,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);
    gen_state_e         state;
    logic [QUAL_W-1:0]  q_lat;
    logic               base_lat;
    logic               scale_go;
    logic               scale_rdy;
    logic [SCALE_W-1:0] scale_val;
    logic [SCALE_W-1:0] scale_lat;
    entry_addr_t        issue_addr;
    logic               issue_valid;
    logic               wr_en;
    entry_addr_t        wr_addr;
    logic [ENTRY_W-1:0] wr_data;
    entry_addr_t        rd_addr;
    logic               accept;

    assign accept      = start && (state == ST_IDLE);
    assign busy        = (state != ST_IDLE);
    assign issue_valid = (state == ST_FILL);
    assign rd_addr     = '{tbl: rd_tbl, idx: rd_idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            q_lat      <= QUAL_W'(1);
            base_lat   <= 1'b0;
            scale_go   <= 1'b0;
            scale_lat  <= '0;
            issue_addr <= '0;
            done       <= 1'b0;
        end else begin
            scale_go <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        q_lat    <= limit_quality(quality);
                        base_lat <= baseline;
                        done     <= 1'b0;
                        scale_go <= 1'b1;
                        state    <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    if (scale_rdy) begin
                        scale_lat  <= scale_val;
                        issue_addr <= '0;
                        state      <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    issue_addr <= issue_addr + 1'b1;
                    if (issue_addr == '1)
                        state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (wr_en && wr_addr == '1) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    qtg_scale i_scale (
        .clk   (clk),
        .rst   (rst),
        .go    (scale_go),
        .q     (q_lat),
        .ready (scale_rdy),
        .scale (scale_val)
    );

    qtg_entry_pipe i_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (issue_valid),
        .in_addr   (issue_addr),
        .scale     (scale_lat),
        .baseline  (base_lat),
        .out_valid (wr_en),
        .out_addr  (wr_addr),
        .out_val   (wr_data)
    );

    qtg_table_ram i_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/qtg_checker.sv
module qtg_checker
    import qtg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [QUAL_W-1:0]  q_lat,
    input logic               base_lat,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [ENTRY_W-1:0] wr_data
);
    AST_Q_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (q_lat >= QUAL_W'(1) && int'(q_lat) <= QUAL_MAX)); // R1

    AST_ENTRY_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data != '0 && int'(wr_data) <= ENTRY_MAX)); // R4

    AST_BASELINE_CAP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && base_lat) |-> int'(wr_data) <= BASE_LIMIT); // R5

    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(wr_en && wr_addr == '1)); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(q_lat) && $stable(base_lat))); // R8

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_en); // R9

endmodule

bind qtg_top qtg_checker i_qtg_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .q_lat    (q_lat),
    .base_lat (base_lat),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/test_qtg_top.sv
module test_qtg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  quality = '0;
    logic        baseline = 1'b0;
    logic        busy;
    logic        done;
    logic        rd_tbl = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    localparam int LUMA [64] = '{
        16, 11, 10, 16, 24, 40, 51, 61,  12, 12, 14, 19, 26, 58, 60, 55,
        14, 13, 16, 24, 40, 57, 69, 56,  14, 17, 22, 29, 51, 87, 80, 62,
        18, 22, 37, 56, 68, 109, 103, 77, 24, 35, 55, 64, 81, 104, 113, 92,
        49, 64, 78, 87, 103, 121, 120, 101, 72, 92, 95, 98, 112, 100, 103, 99
    };

    always #5 clk = ~clk;

    qtg_top i_qtg_top (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .quality  (quality),
        .baseline (baseline),
        .busy     (busy),
        .done     (done),
        .rd_tbl   (rd_tbl),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int chroma_base(int i);
        int r = i / 8;
        int c = i % 8;
        int t [4][4] = '{'{17, 18, 24, 47}, '{18, 21, 26, 66},
                         '{24, 26, 56, 99}, '{47, 66, 99, 99}};
        if (r < 4 && c < 4) return t[r][c];
        return 99;
    endfunction

    function automatic int exp_entry(int q_in, int bl, int tbl, int i);
        int q = q_in;
        int s;
        int b;
        int v;
        if (q < 1) q = 1;
        if (q > 100) q = 100;
        s = (q < 50) ? 5000 / q : 200 - 2 * q;
        b = tbl ? chroma_base(i) : LUMA[i];
        v = (b * s + 50) / 100;
        if (v < 1) v = 1;
        if (v > 32767) v = 32767;
        if (bl != 0 && v > 255) v = 255;
        return v;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic read_entry(int tbl, int i, output int val);
        @(negedge clk);
        rd_tbl = tbl[0];
        rd_idx = i[5:0];
        @(negedge clk);
        val = int'(rd_data);
    endtask

    task automatic launch(int q, int bl);
        @(negedge clk);
        quality  = q[6:0];
        baseline = bl[0];
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check("R7", int'(done), 1, "done after run");
    endtask

    task automatic verify_tables(int q, int bl, string req);
        int v;
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 64; i++) begin
                read_entry(t, i, v);
                check(req, v, exp_entry(q, bl, t, i), $sformatf("q=%0d bl=%0d t=%0d i=%0d", q, bl, t, i));
            end
        end
    endtask

    initial begin
        int v1;
        int v2;
        repeat (3) @(negedge clk);
        check("R10", int'(busy), 0, "busy in reset");
        check("R10", int'(done), 0, "done in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R10", int'(busy), 0, "busy after reset");
        check("R10", int'(done), 0, "done after reset");

        // R7: busy in the cycle after an accepted start, done cleared
        launch(75, 1);
        check("R7", int'(busy), 1, "busy after start");
        check("R7", int'(done), 0, "done low during run");
        wait_done();
        check("R7", int'(busy), 0, "busy after done");
        verify_tables(75, 1, "R3");

        // R1 R2 R3 R4 R5 R6: sweep all qualities, baseline alternating
        for (int q = 0; q <= 110; q++) begin
            launch(q, q % 2);
            wait_done();
            if (q == 100) begin
                read_entry(0, 0, v1);
                check("R4", v1, 1, "zero scale gives 1");
            end
            if (q == 1 || q == 0) begin
                read_entry(0, 0, v1);
                check("R5", v1, (q % 2) ? 255 : 800, "baseline cap at low quality");
            end
            verify_tables(q, q % 2, (q == 0 || q > 100) ? "R1" : (q < 50 ? "R2" : "R6"));
        end

        // R8: second start while busy has no effect
        launch(10, 0);
        repeat (4) @(negedge clk);
        quality  = 7'd90;
        baseline = 1'b1;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        verify_tables(10, 0, "R8");

        // R9: repeated reads while idle are stable
        read_entry(1, 5, v1);
        repeat (30) @(negedge clk);
        read_entry(1, 5, v2);
        check("R9", v2, v1, "idle read stable");
        read_entry(0, 63, v1);
        read_entry(0, 63, v2);
        check("R9", v2, v1, "back to back read stable");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule